// File: doc/BRIEF.md
# Virtual-Channel Wormhole Switch Core

This block is the switching heart of a five-port packet router that uses wormhole switching with virtual channels. Each input port carries a small virtual-channel tag with every flit. The tag steers the flit into one of several private queues that belong to that port. The queues are never multiplexed down per port. Every queue head connects straight into an asymmetric crossbar, so with the default sizes there are twenty crossbar sources and five destinations.

Each output owns a round-robin arbiter that spans all twenty queues. Route computation is minimal: the head flit names its destination output in a small field. Once a head flit wins an output, that output stays bound to the winning queue until the tail flit has left. Packets therefore never interleave on an output, and queue depth stays independent of packet length.

On the output side, every virtual channel has its own ready input. A flit whose channel is blocked downstream waits in its queue and is not lost. Flits on other channels of the same output can pass it in the meantime.

Top module: `vcx_router`

## Requirements
- R1: A flit is 13 bits: bit 12 marks a head flit, bit 11 marks a tail flit, bits 10:8 give the destination output port (this field is meaningful in head flits only), and bits 7:0 are payload. A flit accepted on input port p with tag v enters queue (p, v). If it meets no contention and the ready input for channel v at its destination is high, it appears unchanged on that output with out_vc equal to v, after the second rising edge following its acceptance.
- R2: While reset is high and in the cycle after it is released, every out_valid bit is low, every in_vc_ready bit is high, and every in_overflow bit is low.
- R3: Each queue holds at most 4 flits. The in_vc_ready bit at index p*NUM_VCS+v is low exactly while queue (p, v) is full. The other queues of the same port stay ready.
- R4: A flit presented to a full queue is discarded and leaves the queue contents unchanged. The in_overflow bit of that port is high in the following cycle, and only then.
- R5: Flits leave a queue in the order they entered it.
- R6: An output forwards a flit only if, in the cycle before out_valid rises, the ready bit at index o*NUM_VCS+v of out_vc_ready was high for that flit's channel v. A blocked flit stays queued and is forwarded once that bit goes high.
- R7: After a head flit wins an output, that output carries only flits from the same queue until the tail flit has passed. Packets from different queues never interleave on one output.
- R8: Head flits that contend for one output are served round-robin, and the pointer moves past each winner. Two queues that keep contending with single-flit packets are served alternately.
- R9: Each output forwards at most one flit per cycle, and each queue is dequeued by at most one output per cycle. Different outputs forward in the same cycle without interfering.
- R10: A head flit whose downstream channel is blocked does not delay a head flit on a different, ready channel that targets the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_PORTS | A flit is presented on the input port |
| in_vc | input | NUM_PORTS*log2(NUM_VCS) | Channel tag for each input port |
| in_flit | input | NUM_PORTS*13 | Flit for each input port |
| in_vc_ready | output | NUM_PORTS*NUM_VCS | Queue not full, one bit per port and channel |
| in_overflow | output | NUM_PORTS | Registered flag: a flit was dropped at a full queue |
| out_valid | output | NUM_PORTS | Registered: a flit is on the output |
| out_vc | output | NUM_PORTS*log2(NUM_VCS) | Channel tag of the output flit |
| out_flit | output | NUM_PORTS*13 | Output flit |
| out_vc_ready | input | NUM_PORTS*NUM_VCS | Downstream ready, one bit per output and channel |

## Verification
The bench preloads queues while all downstream channels are held off, then releases them, so that contention is set up deliberately rather than by chance. In one such scenario, two multi-flit packets race for one output. A design that dropped the lock early would interleave their payloads, and the bench would see foreign data between a head and its tail. In another, single-flit packets from two queues compete. A fixed-priority or non-advancing arbiter would send one source twice in a row, and the bench flags that. A fifth write to a filled queue must neither appear on the output nor displace a stored flit. A blocked channel must not hold back a ready channel heading for the same output: a design with shared output blocking would emit nothing in that case.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
  localparam int FLIT_DATA_W = 8;
  localparam int FLIT_DST_W  = 3;

  typedef struct packed {
    logic                   head;
    logic                   tail;
    logic [FLIT_DST_W-1:0]  dst;
    logic [FLIT_DATA_W-1:0] data;
  } flit_t;

  localparam int FLIT_W = $bits(flit_t);
endpackage

// File: rtl/vcx_flit_queue.sv
module vcx_flit_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          wr, rd;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign wr    = push && !full;
  assign rd    = pop && !empty;
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({wr, rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/vcx_rr_arb.sv
module vcx_rr_arb #(
  parameter int N = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;

  always_comb begin
    int j;
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < N; i++) begin
      j = int'(ptr) + i;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any     = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (any) begin
      ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/vcx_out_alloc.sv
module vcx_out_alloc #(
  parameter int NQ = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NQ-1:0] q_valid,
  input  logic [NQ-1:0] q_head,
  input  logic [NQ-1:0] q_tail,
  input  logic [NQ-1:0] q_dst_hit,
  input  logic [NQ-1:0] q_vc_ok,
  output logic [NQ-1:0] gnt,
  output logic          fire
);
  localparam int IW = $clog2(NQ);

  logic          locked;
  logic [IW-1:0] owner;
  logic [NQ-1:0] req, arb_gnt;
  logic [IW-1:0] arb_idx;
  logic          arb_any;
  logic          owner_go;

  assign req = locked ? '0 : (q_valid & q_head & q_dst_hit & q_vc_ok);

  vcx_rr_arb #(.N(NQ)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .gnt     (arb_gnt),
    .gnt_idx (arb_idx),
    .any     (arb_any)
  );

  assign owner_go = locked && q_valid[owner] && q_vc_ok[owner];
  assign fire     = arb_any || owner_go;

  always_comb begin
    if (locked) begin
      gnt        = '0;
      gnt[owner] = owner_go;
    end else begin
      gnt = arb_gnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      owner  <= '0;
    end else if (!locked && arb_any && !q_tail[arb_idx]) begin
      locked <= 1'b1;
      owner  <= arb_idx;
    end else if (owner_go && q_tail[owner]) begin
      locked <= 1'b0;
    end
  end
endmodule

// File: rtl/vcx_router.sv
module vcx_router
  import vcx_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VCS   = 4,
  parameter int Q_DEPTH   = 4
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [NUM_PORTS-1:0]                    in_valid,
  input  logic [NUM_PORTS*$clog2(NUM_VCS)-1:0]    in_vc,
  input  logic [NUM_PORTS*FLIT_W-1:0]             in_flit,
  output logic [NUM_PORTS*NUM_VCS-1:0]            in_vc_ready,
  output logic [NUM_PORTS-1:0]                    in_overflow,
  output logic [NUM_PORTS-1:0]                    out_valid,
  output logic [NUM_PORTS*$clog2(NUM_VCS)-1:0]    out_vc,
  output logic [NUM_PORTS*FLIT_W-1:0]             out_flit,
  input  logic [NUM_PORTS*NUM_VCS-1:0]            out_vc_ready
);
  localparam int VCW = $clog2(NUM_VCS);
  localparam int NQ  = NUM_PORTS * NUM_VCS;

  flit_t            q_flit [NQ];
  logic [NQ-1:0]    q_empty, q_full, q_push, q_pop, q_valid, q_head, q_tail;
  logic [NQ-1:0]    gnt [NUM_PORTS];
  logic [NUM_PORTS-1:0] fire;
  logic [NUM_PORTS*NQ-1:0] grant_flat;
  logic [FLIT_W-1:0] sel_flit [NUM_PORTS];
  logic [VCW-1:0]    sel_vc   [NUM_PORTS];

  // Input side: one queue per port and channel
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar v = 0; v < NUM_VCS; v++) begin : g_vc
      localparam int Q = p * NUM_VCS + v;
      assign q_push[Q] = in_valid[p] && (in_vc[p*VCW +: VCW] == VCW'(v));

      vcx_flit_queue #(.DEPTH(Q_DEPTH), .W(FLIT_W)) u_q (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push[Q]),
        .din   (in_flit[p*FLIT_W +: FLIT_W]),
        .pop   (q_pop[Q]),
        .dout  (q_flit[Q]),
        .empty (q_empty[Q]),
        .full  (q_full[Q])
      );

      assign in_vc_ready[Q] = ~q_full[Q];
      assign q_valid[Q]     = ~q_empty[Q];
      assign q_head[Q]      = q_flit[Q].head;
      assign q_tail[Q]      = q_flit[Q].tail;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_overflow <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        in_overflow[p] <= in_valid[p] &&
                          q_full[p*NUM_VCS + int'(in_vc[p*VCW +: VCW])];
      end
    end
  end

  // Output side: one allocator per crossbar output
  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    logic [NQ-1:0] hit, vc_ok;
    for (genvar q = 0; q < NQ; q++) begin : g_src
      assign hit[q]   = (q_flit[q].dst == FLIT_DST_W'(o));
      assign vc_ok[q] = out_vc_ready[o*NUM_VCS + (q % NUM_VCS)];
    end

    vcx_out_alloc #(.NQ(NQ)) u_alloc (
      .clk       (clk),
      .rst       (rst),
      .q_valid   (q_valid),
      .q_head    (q_head),
      .q_tail    (q_tail),
      .q_dst_hit (hit),
      .q_vc_ok   (vc_ok),
      .gnt       (gnt[o]),
      .fire      (fire[o])
    );

    assign grant_flat[o*NQ +: NQ] = gnt[o];
  end

  always_comb begin
    q_pop = '0;
    for (int o = 0; o < NUM_PORTS; o++) q_pop = q_pop | gnt[o];
  end

  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      sel_flit[o] = '0;
      sel_vc[o]   = '0;
      for (int q = 0; q < NQ; q++) begin
        if (gnt[o][q]) begin
          sel_flit[o] = sel_flit[o] | q_flit[q];
          sel_vc[o]   = sel_vc[o] | VCW'(q % NUM_VCS);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_vc    <= '0;
      out_flit  <= '0;
    end else begin
      out_valid <= fire;
      for (int o = 0; o < NUM_PORTS; o++) begin
        out_vc[o*VCW +: VCW]       <= sel_vc[o];
        out_flit[o*FLIT_W +: FLIT_W] <= sel_flit[o];
      end
    end
  end
endmodule

// File: rtl/vcx_router_chk.sv
module vcx_router_chk #(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VCS   = 4
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic [NUM_PORTS-1:0]                 in_valid,
  input logic [NUM_PORTS*$clog2(NUM_VCS)-1:0] in_vc,
  input logic [NUM_PORTS*NUM_VCS-1:0]         in_vc_ready,
  input logic [NUM_PORTS-1:0]                 in_overflow,
  input logic [NUM_PORTS-1:0]                 out_valid,
  input logic [NUM_PORTS*$clog2(NUM_VCS)-1:0] out_vc,
  input logic [NUM_PORTS*NUM_VCS-1:0]         out_vc_ready,
  input logic [NUM_PORTS*NUM_PORTS*NUM_VCS-1:0] grant_flat,
  input logic [NUM_PORTS*NUM_VCS-1:0]         q_pop,
  input logic [NUM_PORTS*NUM_VCS-1:0]         q_empty
);
  localparam int VCW = $clog2(NUM_VCS);
  localparam int NQ  = NUM_PORTS * NUM_VCS;

  logic [NUM_PORTS*NUM_VCS-1:0] dn_rdy_q, up_rdy_q;
  logic [NUM_PORTS*VCW-1:0]     in_vc_q;

  always_ff @(posedge clk) begin
    dn_rdy_q <= out_vc_ready;
    up_rdy_q <= in_vc_ready;
    in_vc_q  <= in_vc;
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_o
    AST_FWD_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] |-> dn_rdy_q[o*NUM_VCS + int'(out_vc[o*VCW +: VCW])])
      else $error("output forwarded on a blocked channel"); // R6
    AST_ONE_SRC_PER_OUT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant_flat[o*NQ +: NQ]))
      else $error("output granted several queues"); // R9
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    AST_DROP_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
      in_overflow[p] |-> ($past(in_valid[p]) &&
                          !up_rdy_q[p*NUM_VCS + int'(in_vc_q[p*VCW +: VCW])]))
      else $error("overflow flag without a write to a full queue"); // R4
    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid[p]) && !up_rdy_q[p*NUM_VCS + int'(in_vc_q[p*VCW +: VCW])]
       && !$past(rst)) |-> in_overflow[p])
      else $error("write to a full queue not flagged"); // R4
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [NUM_PORTS-1:0] col;
    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_c
      assign col[o] = grant_flat[o*NQ + q];
    end
    AST_ONE_OUT_PER_QUEUE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col))
      else $error("queue dequeued by several outputs"); // R9
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
      q_pop[q] |-> !q_empty[q])
      else $error("empty queue dequeued"); // R5
  end
endmodule

bind vcx_router vcx_router_chk #(.NUM_PORTS(NUM_PORTS), .NUM_VCS(NUM_VCS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_vc        (in_vc),
  .in_vc_ready  (in_vc_ready),
  .in_overflow  (in_overflow),
  .out_valid    (out_valid),
  .out_vc       (out_vc),
  .out_vc_ready (out_vc_ready),
  .grant_flat   (grant_flat),
  .q_pop        (q_pop),
  .q_empty      (q_empty)
);

// File: tb/tb_vcx_router.sv
module tb_vcx_router;
  localparam int P   = 5;
  localparam int V   = 4;
  localparam int VCW = 2;
  localparam int FW  = 13;

  // Table: source port, channel, destination, payload
  localparam int NV = 8;
  localparam int T_SRC [NV] = '{0, 1, 2, 3, 4, 0, 2, 4};
  localparam int T_VC  [NV] = '{0, 1, 2, 3, 0, 3, 1, 2};
  localparam int T_DST [NV] = '{1, 2, 3, 4, 0, 0, 2, 4};
  localparam int T_DAT [NV] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'h16, 8'h27, 8'h38};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst;
  logic [P-1:0]      in_valid;
  logic [P*VCW-1:0]  in_vc;
  logic [P*FW-1:0]   in_flit;
  logic [P*V-1:0]    in_vc_ready;
  logic [P-1:0]      in_overflow;
  logic [P-1:0]      out_valid;
  logic [P*VCW-1:0]  out_vc;
  logic [P*FW-1:0]   out_flit;
  logic [P*V-1:0]    out_vc_ready;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  vcx_router dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit),
    .in_vc_ready(in_vc_ready), .in_overflow(in_overflow), .out_valid(out_valid),
    .out_vc(out_vc), .out_flit(out_flit), .out_vc_ready(out_vc_ready)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [FW-1:0] mk(input logic h, input logic t, input int d, input int dat);
    return {h, t, 3'(d), 8'(dat)};
  endfunction

  task automatic drive(input int p, input int v, input logic [FW-1:0] f);
    in_valid[p]           = 1'b1;
    in_vc[p*VCW +: VCW]   = VCW'(v);
    in_flit[p*FW +: FW]   = f;
  endtask

  initial begin
    logic [7:0] seq [6];
    logic [7:0] first, other;
    rst = 1'b1; in_valid = '0; in_vc = '0; in_flit = '0; out_vc_ready = '1;
    repeat (3) step();
    chk("R2 out_valid in reset", 32'(out_valid), 32'h0);
    rst = 1'b0;
    step();
    chk("R2 out_valid after reset", 32'(out_valid), 32'h0);
    chk("R2 in_vc_ready after reset", 32'(in_vc_ready), 32'hFFFFF);
    chk("R2 in_overflow after reset", 32'(in_overflow), 32'h0);

    // R1: table walk of uncontested single-flit packets
    for (int i = 0; i < NV; i++) begin
      logic [FW-1:0] f;
      f = mk(1'b1, 1'b1, T_DST[i], T_DAT[i]);
      drive(T_SRC[i], T_VC[i], f);
      step();
      in_valid = '0;
      step();
      chk($sformatf("R1 row%0d out_valid", i), 32'(out_valid), 32'(1 << T_DST[i]));
      chk($sformatf("R1 row%0d out_vc", i), 32'(out_vc[T_DST[i]*VCW +: VCW]), 32'(T_VC[i]));
      chk($sformatf("R1 row%0d out_flit", i), 32'(out_flit[T_DST[i]*FW +: FW]), 32'(f));
      step();
      chk($sformatf("R9 row%0d single beat", i), 32'(out_valid), 32'h0);
    end

    // R3 / R4: fill queue (0,1) while blocked, then overflow it
    out_vc_ready = '0;
    for (int k = 0; k < 5; k++) begin
      if (k == 4) begin
        chk("R3 full queue not ready", 32'(in_vc_ready[1]), 32'h0);
        chk("R3 sibling queue ready", 32'(in_vc_ready[0]), 32'h1);
      end
      drive(0, 1, mk(k == 0, k == 3, 2, 8'h80 + k));
      step();
    end
    in_valid = '0;
    chk("R4 overflow flagged", 32'(in_overflow[0]), 32'h1);
    step();
    chk("R4 overflow one cycle", 32'(in_overflow[0]), 32'h0);
    out_vc_ready = '1;
    for (int i = 0; i < 6; i++) begin
      step();
      if (i < 4) begin
        chk($sformatf("R5 drain valid %0d", i), 32'(out_valid[2]), 32'h1);
        chk($sformatf("R5 drain order %0d", i), 32'(out_flit[2*FW +: 8]), 32'(8'h80 + i));
        chk($sformatf("R1 drain vc %0d", i), 32'(out_vc[2*VCW +: VCW]), 32'h1);
      end else begin
        chk($sformatf("R4 dropped flit absent %0d", i), 32'(out_valid[2]), 32'h0);
      end
    end

    // R7: two 3-flit packets race for output 3
    out_vc_ready = '0;
    for (int k = 0; k < 3; k++) begin
      drive(0, 0, mk(k == 0, k == 2, 3, 8'h10 + k));
      drive(1, 0, mk(k == 0, k == 2, 3, 8'h20 + k));
      step();
    end
    in_valid = '0;
    out_vc_ready = '1;
    for (int k = 0; k < 6; k++) begin
      step();
      chk($sformatf("R7 beat %0d valid", k), 32'(out_valid[3]), 32'h1);
      seq[k] = out_flit[3*FW +: 8];
    end
    first = {seq[0][7:4], 4'h0};
    other = (first == 8'h10) ? 8'h20 : 8'h10;
    chk("R7 first packet source", 32'(first == 8'h10 || first == 8'h20), 32'h1);
    for (int k = 0; k < 6; k++) begin
      chk($sformatf("R7 no interleave beat %0d", k), 32'(seq[k]),
          32'((k < 3) ? (first + k) : (other + k - 3)));
    end
    step();
    chk("R7 output idle after packets", 32'(out_valid[3]), 32'h0);

    // R8: two queues with two single-flit packets each to output 4
    out_vc_ready = '0;
    for (int k = 0; k < 2; k++) begin
      drive(0, 0, mk(1'b1, 1'b1, 4, 8'h30 + k));
      drive(1, 0, mk(1'b1, 1'b1, 4, 8'h40 + k));
      step();
    end
    in_valid = '0;
    out_vc_ready = '1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk($sformatf("R8 beat %0d valid", k), 32'(out_valid[4]), 32'h1);
      seq[k] = out_flit[4*FW +: 8];
    end
    chk("R8 alternate 0-1", 32'(seq[0][7:4] != seq[1][7:4]), 32'h1);
    chk("R8 alternate 1-2", 32'(seq[2][7:4]), 32'(seq[0][7:4]));
    chk("R8 alternate 2-3", 32'(seq[3][7:4]), 32'(seq[1][7:4]));
    chk("R5 per-source order", 32'({seq[0][3:0], seq[1][3:0], seq[2][3:0], seq[3][3:0]}), 32'h0011);

    // R6 / R10: blocked channel 2 on output 1 must not stall channel 3
    out_vc_ready = '0;
    drive(2, 2, mk(1'b1, 1'b1, 1, 8'h50));
    drive(3, 3, mk(1'b1, 1'b1, 1, 8'h60));
    step();
    in_valid = '0;
    out_vc_ready = '1;
    out_vc_ready[1*V + 2] = 1'b0;
    step();
    chk("R10 ready channel passes", 32'(out_valid[1]), 32'h1);
    chk("R10 ready channel data", 32'(out_flit[1*FW +: 8]), 32'h60);
    chk("R10 ready channel vc", 32'(out_vc[1*VCW +: VCW]), 32'h3);
    step();
    chk("R6 blocked channel held", 32'(out_valid[1]), 32'h0);
    step();
    chk("R6 blocked channel still held", 32'(out_valid[1]), 32'h0);
    out_vc_ready[1*V + 2] = 1'b1;
    step();
    chk("R6 released flit valid", 32'(out_valid[1]), 32'h1);
    chk("R6 released flit data", 32'(out_flit[1*FW +: 8]), 32'h50);
    chk("R6 released flit vc", 32'(out_vc[1*VCW +: VCW]), 32'h2);

    // R9: two outputs in the same cycle
    drive(0, 3, mk(1'b1, 1'b1, 0, 8'h70));
    drive(4, 1, mk(1'b1, 1'b1, 1, 8'h71));
    step();
    in_valid = '0;
    step();
    chk("R9 parallel outputs", 32'(out_valid), 32'h3);
    chk("R9 output 0 data", 32'(out_flit[0*FW +: 8]), 32'h70);
    chk("R9 output 1 data", 32'(out_flit[1*FW +: 8]), 32'h71);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule